// File: doc/BRIEF.md
# Write-Completion Status Read Responder

This block drives the read data path of a byte-alterable non-volatile memory. It handles ordinary reads and also reads made while an internal programming cycle is running. When the memory is idle, a read returns the array byte at the read address. While the busy flag is high, a read returns a status byte instead. This lets a host detect early that a byte or page write has finished, using either of two methods.

The first method is data polling on the top bit. The host rereads the address it wrote last. While programming runs, the top bit is the inverse of the top bit it wrote. Once programming is over, the true value comes back. The second method uses the next bit down, which flips on every new read access while the device is busy. The host reads twice and compares; when the bit stops flipping, the write is done.

A separate drive-enable output stands in for the tri-state control of the shared bus. The array and the write sequencer sit outside this block. The array presents `arr_rdata` combinationally for `rd_addr`. The sequencer supplies `busy`, the last written address and byte, and `poll_inhibit`. `poll_inhibit` is raised when the last write attempt was refused because the memory was write-protected.

The read controller has three states:
- `BUS_RELEASED`: the bus is not driven.
- `ARRAY_READ`: array data is presented.
- `STATUS_READ`: the status byte is presented.

Every clock the controller moves to a state chosen from the strobes and the busy flag, whatever state it is in:
- It goes to `BUS_RELEASED` when either strobe is high.
- It goes to `ARRAY_READ` when both strobes are low and `busy` is low.
- It goes to `STATUS_READ` when both strobes are low and `busy` is high.

All outputs are registered, so they follow the sampled inputs by one clock.

Top module: `wcs_status_responder`

## Requirements
- R1: One clock after a cycle in which `ce_n` or `oe_n` is high, `drive_en` is 0 and `rd_data` is all zeros. One clock after a cycle with both strobes low, `drive_en` is 1.
- R2: For a read sampled with `busy` high, `poll_inhibit` low and `rd_addr` equal to `last_addr`, bit 7 of `rd_data` is the inverse of bit 7 of `last_data`.
- R3: A read access starts in a cycle where both strobes are low after a cycle where they were not. Each access start sampled with `busy` high inverts the toggle bit, bit 6 of `rd_data` during busy reads. The inversion is visible in the first output cycle of that access. An access held low over many cycles inverts it once. Access starts sampled with `busy` low leave it unchanged.
- R4: For a read sampled with `busy` high, bits 5 down to 0 of `rd_data` are zero.
- R5: For a read sampled with `busy` low, `rd_data` equals the `arr_rdata` value of the sampled cycle.
- R6: For a read sampled with `busy` high and `poll_inhibit` high at the last address, bit 7 of `rd_data` equals bit 7 of `last_data`, not inverted.
- R7: For a read sampled with `busy` high at an address other than `last_addr`, bit 7 of `rd_data` is 0.
- R8: Reset sets the toggle bit to 0. It is never reinitialised when a busy period starts, so a new busy period continues from the value the previous one left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_addr | input | ADDR_W | Read address, also handed to the array |
| arr_rdata | input | DATA_W | Array byte at `rd_addr` |
| busy | input | 1 | Internal programming cycle running |
| poll_inhibit | input | 1 | Last write attempt was refused by protection |
| last_addr | input | ADDR_W | Address of the last byte written |
| last_data | input | DATA_W | Last byte written |
| rd_data | output | DATA_W | Read data toward the bus |
| drive_en | output | 1 | Bus drive enable, stands in for tri-state control |

## Verification
The hardest situation to reach from the ports is the toggle bit crossing busy boundaries. It must keep its value through idle accesses and then resume in the next busy period. It must also stay put when `busy` changes in the middle of a held access.

The stimulus builds an odd number of busy reads so the bit ends at 1. It then drops `busy`, makes idle accesses, and raises `busy` again; the first new status read must show 0. Separate sequences raise and lower `busy` while both strobes stay low. A final mid-run reset shows the bit returning to its reset value.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
    typedef enum logic [1:0] {
        BUS_RELEASED = 2'd0,
        ARRAY_READ   = 2'd1,
        STATUS_READ  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/wcs_access_detect.sv
module wcs_access_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic sel,
    output logic access_start
);
    logic sel_q;

    assign sel          = ~ce_n & ~oe_n;
    assign access_start = sel & ~sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel;
    end
endmodule

// File: rtl/wcs_toggle_keeper.sv
module wcs_toggle_keeper (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic access_start,
    output logic tog_next
);
    logic tog_q;

    // Flip only on a fresh access while programming; value persists otherwise.
    assign tog_next = tog_q ^ (busy & access_start);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_next;
    end
endmodule

// File: rtl/wcs_status_encode.sv
module wcs_status_encode #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    input  logic              poll_inhibit,
    input  logic              tog,
    output logic [DATA_W-1:0] status
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    logic addr_hit;
    logic poll_val;

    assign addr_hit = (rd_addr == last_addr);
    assign poll_val = addr_hit & (poll_inhibit ? last_data[POLL_BIT] : ~last_data[POLL_BIT]);

    genvar b;
    generate
        for (b = 0; b < DATA_W; b++) begin : g_bit
            if (b == POLL_BIT) begin : g_poll
                assign status[b] = poll_val;
            end else if (b == TOG_BIT) begin : g_tog
                assign status[b] = tog;
            end else begin : g_rsvd
                assign status[b] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/wcs_read_fsm.sv
module wcs_read_fsm
    import wcs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              busy,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              drive_en
);
    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] payload_q;

    always_comb begin
        state_d = BUS_RELEASED;
        unique case (state_q)
            BUS_RELEASED,
            ARRAY_READ,
            STATUS_READ: begin
                if (!sel)      state_d = BUS_RELEASED;
                else if (busy) state_d = STATUS_READ;
                else           state_d = ARRAY_READ;
            end
            default:           state_d = BUS_RELEASED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= BUS_RELEASED;
            payload_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_d)
                STATUS_READ:  payload_q <= status;
                ARRAY_READ:   payload_q <= arr_rdata;
                default:      payload_q <= '0;
            endcase
        end
    end

    always_comb begin
        drive_en = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            BUS_RELEASED: begin
                drive_en = 1'b0;
                rd_data  = '0;
            end
            ARRAY_READ,
            STATUS_READ: begin
                drive_en = 1'b1;
                rd_data  = payload_q;
            end
            default: begin
                drive_en = 1'b0;
                rd_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/wcs_status_responder.sv
module wcs_status_responder #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              busy,
    input  logic              poll_inhibit,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              drive_en
);
    logic              sel;
    logic              access_start;
    logic              tog_next;
    logic [DATA_W-1:0] status;

    wcs_access_detect u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce_n         (ce_n),
        .oe_n         (oe_n),
        .sel          (sel),
        .access_start (access_start)
    );

    wcs_toggle_keeper u_toggle (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy),
        .access_start (access_start),
        .tog_next     (tog_next)
    );

    wcs_status_encode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_encode (
        .rd_addr      (rd_addr),
        .last_addr    (last_addr),
        .last_data    (last_data),
        .poll_inhibit (poll_inhibit),
        .tog          (tog_next),
        .status       (status)
    );

    wcs_read_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .busy      (busy),
        .status    (status),
        .arr_rdata (arr_rdata),
        .rd_data   (rd_data),
        .drive_en  (drive_en)
    );
endmodule

// File: rtl/wcs_status_responder_chk.sv
module wcs_status_responder_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] arr_rdata,
    input logic              busy,
    input logic              poll_inhibit,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              drive_en
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    logic rd_sel;
    assign rd_sel = ~ce_n & ~oe_n;

    assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel |=> (!drive_en && rd_data == '0));

    assert_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |=> drive_en);

    assert_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && busy && !poll_inhibit && rd_addr == last_addr)
        |=> rd_data[POLL_BIT] == !$past(last_data[POLL_BIT]));

    assert_held_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && busy && $past(rd_sel && busy)) |=> $stable(rd_data[TOG_BIT]));

    assert_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && busy) |=> rd_data[TOG_BIT-1:0] == '0);

    assert_array_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && !busy) |=> rd_data == $past(arr_rdata));

    assert_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && busy && poll_inhibit && rd_addr == last_addr)
        |=> rd_data[POLL_BIT] == $past(last_data[POLL_BIT]));

    assert_other_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && busy && rd_addr != last_addr) |=> !rd_data[POLL_BIT]);
endmodule

bind wcs_status_responder wcs_status_responder_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .rd_addr      (rd_addr),
    .arr_rdata    (arr_rdata),
    .busy         (busy),
    .poll_inhibit (poll_inhibit),
    .last_addr    (last_addr),
    .last_data    (last_data),
    .rd_data      (rd_data),
    .drive_en     (drive_en)
);

// File: tb/wcs_status_responder_test.sv
module wcs_status_responder_test;
    localparam int DW = 8;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_rdata;
    logic          busy = 1'b0, poll_inhibit = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;
    logic [DW-1:0] rd_data;
    logic          drive_en;

    int total = 0, bad = 0;
    bit done = 0;

    // behavioural model state
    bit       m_valid = 0, m_prev_sel = 0, m_tog = 0;
    bit       e_drive = 0, e_busy = 0;
    bit [7:0] e_data = 0;
    string    e_tag7 = "R2", tog_tag = "R3";

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] arr_of(input logic [AW-1:0] a);
        return 8'(a[7:0] * 8'd7 + 8'h13) ^ 8'(a[14:8]);
    endfunction
    assign arr_rdata = arr_of(rd_addr);

    wcs_status_responder uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .rd_addr(rd_addr),
        .arr_rdata(arr_rdata), .busy(busy), .poll_inhibit(poll_inhibit),
        .last_addr(last_addr), .last_data(last_data), .rd_data(rd_data), .drive_en(drive_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        if (!m_valid) return;
        chk(drive_en === e_drive, "R1 drive_en", {7'd0, drive_en}, {7'd0, e_drive});
        if (!e_drive)
            chk(rd_data === 8'h00, "R1 released data", rd_data, 8'h00);
        else if (e_busy) begin
            chk(rd_data[7] === e_data[7], e_tag7, {7'd0, rd_data[7]}, {7'd0, e_data[7]});
            chk(rd_data[6] === e_data[6], tog_tag, {7'd0, rd_data[6]}, {7'd0, e_data[6]});
            chk(rd_data[5:0] === 6'd0, "R4 reserved bits", {2'd0, rd_data[5:0]}, 8'h00);
        end else
            chk(rd_data === e_data, "R5 array data", rd_data, e_data);
    endtask

    task automatic cyc(input logic ce, input logic oe, input logic bz, input logic [AW-1:0] a);
        bit sel, start, hit;
        @(negedge clk);
        compare();
        ce_n = ce; oe_n = oe; busy = bz; rd_addr = a;
        sel   = !ce && !oe;
        start = sel && !m_prev_sel;
        if (start && bz) m_tog = !m_tog;
        m_prev_sel = sel;
        hit = (a == last_addr);
        e_drive = sel;
        e_busy  = bz;
        if (!sel) e_data = 8'h00;
        else if (bz) begin
            e_data[7]   = hit ? (poll_inhibit ? last_data[7] : !last_data[7]) : 1'b0;
            e_data[6]   = m_tog;
            e_data[5:0] = 6'd0;
            e_tag7 = !hit ? "R7 foreign address" : (poll_inhibit ? "R6 inhibited poll" : "R2 poll bit");
        end else e_data = arr_of(a);
        m_valid = 1;
    endtask

    task automatic read_pulse(input logic bz, input logic [AW-1:0] a, input int len);
        for (int i = 0; i < len; i++) cyc(1'b0, 1'b0, bz, a);
        cyc(1'b1, 1'b1, bz, a);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // reset state: bus released (R1), toggle cleared (R8)
        repeat (3) @(negedge clk);
        chk(drive_en === 1'b0, "R1 reset drive", {7'd0, drive_en}, 8'h00);
        chk(rd_data === 8'h00, "R1 reset data", rd_data, 8'h00);
        rst_n = 1'b1;

        // idle reads from the array, R5
        read_pulse(1'b0, 15'h0000, 2);
        read_pulse(1'b0, 15'h7FFF, 1);
        for (int k = 0; k < 6; k++) cyc(1'b0, 1'b0, 1'b0, 15'(k * 1111));
        cyc(1'b1, 1'b1, 1'b0, '0);
        // one strobe only: released, R1
        cyc(1'b0, 1'b1, 1'b0, 15'h0003);
        cyc(1'b1, 1'b0, 1'b0, 15'h0003);
        cyc(1'b1, 1'b0, 1'b1, 15'h0003);

        // busy, polling last address, R2 R3 R4
        last_addr = 15'h1234; last_data = 8'h3C;
        for (int k = 0; k < 5; k++) read_pulse(1'b1, 15'h1234, 1);
        last_data = 8'hA7;
        read_pulse(1'b1, 15'h1234, 2);
        // held access toggles once, R3
        read_pulse(1'b1, 15'h1234, 6);
        // other address, R7
        read_pulse(1'b1, 15'h0042, 2);
        // inhibited polling, R6
        poll_inhibit = 1'b1;
        read_pulse(1'b1, 15'h1234, 1);
        last_data = 8'h15;
        read_pulse(1'b1, 15'h1234, 1);
        poll_inhibit = 1'b0;

        // busy falls during a held access: array data, no flip
        cyc(1'b0, 1'b0, 1'b1, 15'h1234);
        cyc(1'b0, 1'b0, 1'b0, 15'h1234);
        cyc(1'b0, 1'b0, 1'b0, 15'h1234);
        cyc(1'b0, 1'b0, 1'b1, 15'h1234);
        cyc(1'b1, 1'b1, 1'b0, 15'h1234);

        // idle accesses leave toggle, carry into next busy period, R8
        tog_tag = "R8 toggle carry";
        for (int k = 0; k < 3; k++) read_pulse(1'b0, 15'(k + 7), 1);
        for (int k = 0; k < 3; k++) read_pulse(1'b1, 15'h1234, 1);
        cyc(1'b1, 1'b1, 1'b0, '0);

        // mid-run reset returns toggle to 0, R8
        @(negedge clk); compare(); m_valid = 0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(drive_en === 1'b0, "R8 reset drive", {7'd0, drive_en}, 8'h00);
        rst_n = 1'b1; m_tog = 0; m_prev_sel = 0;
        read_pulse(1'b1, 15'h1234, 1);
        read_pulse(1'b1, 15'h1234, 1);
        cyc(1'b1, 1'b1, 1'b0, '0);
        @(negedge clk); compare();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule